// File: doc/BRIEF.md
# Passive SPI Bus Monitor

This block listens to an SPI bus without driving it. It watches the serial clock, chip select and both data lines, and rebuilds the words that travel in each direction. The bus lines are asynchronous to the system clock. They pass through a two-stage synchroniser, and the block detects serial clock transitions in the system clock domain. For each completed word it reports the controller-to-peripheral word and the peripheral-to-controller word together.

Configuration inputs set five things: clock idle level, clock phase, chip-select active level, bit order and word length. When a word completes, the block raises a single-cycle valid strobe. At the same time it presents both words, a warning flag and a wrapping count of completed words. The warning flag is set when chip select was not active at the first sampled bit of the word. The word is still reported, not discarded.

Top module: `spi_monitor`

## Requirements
- R1: A bit is sampled on a rising serial-clock edge when cfg_cpol equals cfg_cpha (modes 0 and 3), and on a falling edge when they differ (modes 1 and 2). The mode number is {cfg_cpol, cfg_cpha}.
- R2: While the serial clock does not change, changes on chip select or the data lines shift in no bit, emit no word and leave every output unchanged.
- R3: On each sampling edge, the MOSI bit and the MISO bit are captured together into two separate words, mosi_word and miso_word.
- R4: With cfg_lsb_first=0, the k-th sampled bit of a word (k counted from 0) lands at bit cfg_word_len-1-k. With cfg_lsb_first=1, it lands at bit k. Output bits at cfg_word_len and above are 0.
- R5: Word length is cfg_word_len, from 1 to MAX_WORD. The word is emitted when the sampled-bit count reaches that length, and the next word then starts from an empty state.
- R6: cfg_cs_high=0 makes a low chip select the active level, and cfg_cs_high=1 makes a high chip select the active level.
- R7: word_warn is 1 for a word exactly when chip select was at its inactive level at that word's first sampled bit.
- R8: word_count increases by one, modulo 2^CNT_W, in the cycle that word_valid is high, and changes at no other time except reset.
- R9: word_valid is high for one cycle per word. mosi_word, miso_word and word_warn change only together with word_valid and then hold. word_valid rises after the third rising system-clock edge that follows the bus change forming the word's last sampling edge.
- R10: A synchronous reset clears all outputs, the partial word and the bit position. The stored previous clock level is loaded with cfg_cpol, so the first transition after reset is judged against the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| spi_sck | input | 1 | Observed serial clock |
| spi_cs | input | 1 | Observed chip select |
| spi_mosi | input | 1 | Observed controller-to-peripheral data |
| spi_miso | input | 1 | Observed peripheral-to-controller data |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase: 0 samples on leading edge, 1 on trailing edge |
| cfg_cs_high | input | 1 | Chip select active level (1 = high) |
| cfg_lsb_first | input | 1 | Bit order: 1 = least significant bit first |
| cfg_word_len | input | LEN_W | Bits per word, 1 to MAX_WORD |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| mosi_word | output | MAX_WORD | Last completed MOSI word, right-aligned |
| miso_word | output | MAX_WORD | Last completed MISO word, right-aligned |
| word_warn | output | 1 | Chip select was inactive at the first bit of the last word |
| word_count | output | CNT_W | Completed words, wrapping |

## Verification
The assertions rely on three properties of the inputs. The configuration inputs change only while reset is held. cfg_word_len stays between 1 and MAX_WORD. Each serial clock level lasts at least four system clock cycles. Under these conditions two completed words can never fall on neighbouring cycles, and the length mask applies to stable settings. The stimulus writes configuration only inside a reset window, uses lengths of 1, 5, 8 and 32, and holds each serial clock level for four system cycles.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;

    typedef enum logic [1:0] {
        MODE_0 = 2'd0,
        MODE_1 = 2'd1,
        MODE_2 = 2'd2,
        MODE_3 = 2'd3
    } spi_mode_e;

    function automatic spi_mode_e mode_of(input logic cpol, input logic cpha);
        return spi_mode_e'({cpol, cpha});
    endfunction

    // Level the serial clock takes right after a sampling edge.
    function automatic logic sample_level(input spi_mode_e mode);
        case (mode)
            MODE_0, MODE_3: return 1'b1;
            default:        return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/spi_mon_sync.sv
module spi_mon_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din[b]};
        end

        always_ff @(posedge clk) begin
            chain_q <= chain_d;
        end

        assign dout[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/spi_mon_edge.sv
module spi_mon_edge
    import spi_mon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sck_s,
    input  logic cfg_cpol,
    input  logic cfg_cpha,
    output logic sample
);
    logic prev_d, prev_q;
    logic want_level;

    always_comb begin
        want_level = sample_level(mode_of(cfg_cpol, cfg_cpha));
        prev_d     = rst ? cfg_cpol : sck_s;
        sample     = !rst && (sck_s != prev_q) && (sck_s == want_level);
    end

    always_ff @(posedge clk) begin
        prev_q <= prev_d;
    end
endmodule

// File: rtl/spi_mon_asm.sv
module spi_mon_asm #(
    parameter int MAX_WORD = 32,
    parameter int CNT_W    = 16,
    parameter int LEN_W    = $clog2(MAX_WORD + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample,
    input  logic                cs_inactive,
    input  logic                mosi_bit,
    input  logic                miso_bit,
    input  logic                cfg_lsb_first,
    input  logic [LEN_W-1:0]    cfg_word_len,
    output logic                valid,
    output logic [MAX_WORD-1:0] mosi_word,
    output logic [MAX_WORD-1:0] miso_word,
    output logic                warn,
    output logic [CNT_W-1:0]    count
);
    typedef struct packed {
        logic [MAX_WORD-1:0] mosi_acc;
        logic [MAX_WORD-1:0] miso_acc;
        logic [LEN_W-1:0]    bitcnt;
        logic                warn_acc;
        logic                valid;
        logic [MAX_WORD-1:0] mosi_out;
        logic [MAX_WORD-1:0] miso_out;
        logic                warn_out;
        logic [CNT_W-1:0]    count;
    } asm_state_t;

    asm_state_t st_d, st_q;
    logic [LEN_W-1:0] slot;
    logic             last_bit;
    logic             word_warn_d;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        slot       = cfg_lsb_first ? st_q.bitcnt
                                   : LEN_W'(cfg_word_len - LEN_W'(1) - st_q.bitcnt);
        last_bit   = ({1'b0, st_q.bitcnt} + (LEN_W + 1)'(1)) == {1'b0, cfg_word_len};
        word_warn_d = (st_q.bitcnt == '0) ? cs_inactive : st_q.warn_acc;

        if (sample) begin
            for (int i = 0; i < MAX_WORD; i++) begin
                if (LEN_W'(i) == slot) begin
                    st_d.mosi_acc[i] = mosi_bit;
                    st_d.miso_acc[i] = miso_bit;
                end
            end
            if (last_bit) begin
                st_d.mosi_out = st_d.mosi_acc;
                st_d.miso_out = st_d.miso_acc;
                st_d.warn_out = word_warn_d;
                st_d.valid    = 1'b1;
                st_d.count    = st_q.count + CNT_W'(1);
                st_d.mosi_acc = '0;
                st_d.miso_acc = '0;
                st_d.bitcnt   = '0;
                st_d.warn_acc = 1'b0;
            end else begin
                st_d.bitcnt   = st_q.bitcnt + LEN_W'(1);
                st_d.warn_acc = word_warn_d;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign valid     = st_q.valid;
    assign mosi_word = st_q.mosi_out;
    assign miso_word = st_q.miso_out;
    assign warn      = st_q.warn_out;
    assign count     = st_q.count;
endmodule

// File: rtl/spi_monitor.sv
module spi_monitor #(
    parameter int MAX_WORD = 32,
    parameter int CNT_W    = 16,
    parameter int LEN_W    = $clog2(MAX_WORD + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                spi_sck,
    input  logic                spi_cs,
    input  logic                spi_mosi,
    input  logic                spi_miso,
    input  logic                cfg_cpol,
    input  logic                cfg_cpha,
    input  logic                cfg_cs_high,
    input  logic                cfg_lsb_first,
    input  logic [LEN_W-1:0]    cfg_word_len,
    output logic                word_valid,
    output logic [MAX_WORD-1:0] mosi_word,
    output logic [MAX_WORD-1:0] miso_word,
    output logic                word_warn,
    output logic [CNT_W-1:0]    word_count
);
    localparam int N_LINES = 4;

    logic [N_LINES-1:0] lines_s;
    logic               sample;

    spi_mon_sync #(.WIDTH(N_LINES), .STAGES(2)) u_sync (
        .clk  (clk),
        .din  ({spi_miso, spi_mosi, spi_cs, spi_sck}),
        .dout (lines_s)
    );

    spi_mon_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .sck_s    (lines_s[0]),
        .cfg_cpol (cfg_cpol),
        .cfg_cpha (cfg_cpha),
        .sample   (sample)
    );

    spi_mon_asm #(.MAX_WORD(MAX_WORD), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_asm (
        .clk           (clk),
        .rst           (rst),
        .sample        (sample),
        .cs_inactive   (lines_s[1] != cfg_cs_high),
        .mosi_bit      (lines_s[2]),
        .miso_bit      (lines_s[3]),
        .cfg_lsb_first (cfg_lsb_first),
        .cfg_word_len  (cfg_word_len),
        .valid         (word_valid),
        .mosi_word     (mosi_word),
        .miso_word     (miso_word),
        .warn          (word_warn),
        .count         (word_count)
    );
endmodule

// File: rtl/spi_monitor_chk.sv
module spi_monitor_chk #(
    parameter int MAX_WORD = 32,
    parameter int CNT_W    = 16,
    parameter int LEN_W    = $clog2(MAX_WORD + 1)
) (
    input logic                clk,
    input logic                rst,
    input logic [LEN_W-1:0]    cfg_word_len,
    input logic                word_valid,
    input logic [MAX_WORD-1:0] mosi_word,
    input logic [MAX_WORD-1:0] miso_word,
    input logic                word_warn,
    input logic [CNT_W-1:0]    word_count
);
    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!word_valid && !$past(rst)) |->
            ($stable(mosi_word) && $stable(miso_word) && $stable(word_warn)));

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (word_valid && !$past(rst)) |-> (word_count == CNT_W'($past(word_count) + 1'b1)));

    // R8
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!word_valid && !$past(rst)) |-> $stable(word_count));

    // R4
    len_mask_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> (((mosi_word >> cfg_word_len) == '0) && ((miso_word >> cfg_word_len) == '0)));

    // R10
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!word_valid && (word_count == '0) && !word_warn));
endmodule

bind spi_monitor spi_monitor_chk #(.MAX_WORD(MAX_WORD), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_word_len (cfg_word_len),
    .word_valid   (word_valid),
    .mosi_word    (mosi_word),
    .miso_word    (miso_word),
    .word_warn    (word_warn),
    .word_count   (word_count)
);

// File: tb/spi_monitor_tb.sv
`timescale 1ns/1ps
module spi_monitor_tb;
    localparam int MAX_WORD = 32;
    localparam int CNT_W    = 4;
    localparam int LEN_W    = $clog2(MAX_WORD + 1);
    localparam int HALF     = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_sck = 1'b0, spi_cs = 1'b1, spi_mosi = 1'b0, spi_miso = 1'b0;
    logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_cs_high = 1'b0, cfg_lsb_first = 1'b0;
    logic [LEN_W-1:0] cfg_word_len = LEN_W'(8);
    logic                word_valid;
    logic [MAX_WORD-1:0] mosi_word, miso_word;
    logic                word_warn;
    logic [CNT_W-1:0]    word_count;

    int n_cmp = 0, n_bad = 0, exp_cnt = 0;
    bit done = 0;

    always #5 clk = ~clk;

    spi_monitor #(.MAX_WORD(MAX_WORD), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs(spi_cs),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_cs_high(cfg_cs_high),
        .cfg_lsb_first(cfg_lsb_first), .cfg_word_len(cfg_word_len),
        .word_valid(word_valid), .mosi_word(mosi_word), .miso_word(miso_word),
        .word_warn(word_warn), .word_count(word_count)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: bus seen at each rising edge, results delayed by two edges.
    logic m_prev;
    int   m_k;
    logic [MAX_WORD-1:0] m_acc_o, m_acc_i;
    logic m_wacc;
    logic e_v[3];
    logic [MAX_WORD-1:0] e_o[3], e_i[3];
    logic e_w[3];
    int   e_c[3];
    logic n_v; logic [MAX_WORD-1:0] n_o, n_i; logic n_w; int n_c;

    always @(posedge clk) begin
        if (rst) begin
            m_prev = cfg_cpol; m_k = 0; m_acc_o = '0; m_acc_i = '0; m_wacc = 0;
            n_v = 0; n_o = '0; n_i = '0; n_w = 0; n_c = 0;
            for (int j = 0; j < 3; j++) begin
                e_v[j] = 0; e_o[j] = '0; e_i[j] = '0; e_w[j] = 0; e_c[j] = 0;
            end
        end else begin
            n_v = 0;
            if (spi_sck !== m_prev) begin
                m_prev = spi_sck;
                if (spi_sck == (cfg_cpol ~^ cfg_cpha)) begin
                    int pos;
                    if (m_k == 0) m_wacc = (spi_cs != cfg_cs_high);
                    pos = cfg_lsb_first ? m_k : (int'(cfg_word_len) - 1 - m_k);
                    m_acc_o[pos] = spi_mosi;
                    m_acc_i[pos] = spi_miso;
                    m_k++;
                    if (m_k == int'(cfg_word_len)) begin
                        n_v = 1; n_o = m_acc_o; n_i = m_acc_i; n_w = m_wacc;
                        n_c = (n_c + 1) % (1 << CNT_W);
                        m_acc_o = '0; m_acc_i = '0; m_k = 0;
                    end
                end
            end
            for (int j = 2; j > 0; j--) begin
                e_v[j] = e_v[j-1]; e_o[j] = e_o[j-1]; e_i[j] = e_i[j-1];
                e_w[j] = e_w[j-1]; e_c[j] = e_c[j-1];
            end
            e_v[0] = n_v; e_o[0] = n_o; e_i[0] = n_i; e_w[0] = n_w; e_c[0] = n_c;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(word_valid == e_v[2], "R9 valid strobe timing", 64'(word_valid), 64'(e_v[2]));
            chk(mosi_word == e_o[2], "R3 mosi word vs model", 64'(mosi_word), 64'(e_o[2]));
            chk(miso_word == e_i[2], "R3 miso word vs model", 64'(miso_word), 64'(e_i[2]));
            chk(word_warn == e_w[2], "R7 warn vs model", 64'(word_warn), 64'(e_w[2]));
            chk(int'(word_count) == e_c[2], "R8 count vs model", 64'(word_count), 64'(e_c[2]));
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic apply_cfg(input logic cpol, input logic cpha, input logic csh,
                             input logic lsb, input int len);
        @(negedge clk);
        rst = 1'b1;
        cfg_cpol = cpol; cfg_cpha = cpha; cfg_cs_high = csh;
        cfg_lsb_first = lsb; cfg_word_len = LEN_W'(len);
        spi_sck = cpol; spi_cs = ~csh;
        wait_clk(5);
        rst = 1'b0;
        exp_cnt = 0;
        wait_clk(2);
    endtask

    task automatic send_bits(input logic [MAX_WORD-1:0] mo, input logic [MAX_WORD-1:0] mi,
                             input bit cs_act, input int nbits);
        spi_cs = cs_act ? cfg_cs_high : ~cfg_cs_high;
        for (int k = 0; k < nbits; k++) begin
            int b;
            b = cfg_lsb_first ? k : (int'(cfg_word_len) - 1 - k);
            if (!cfg_cpha) begin
                spi_mosi = mo[b]; spi_miso = mi[b];
                wait_clk(HALF); spi_sck = ~spi_sck;
                wait_clk(HALF); spi_sck = ~spi_sck;
            end else begin
                spi_sck = ~spi_sck; spi_mosi = mo[b]; spi_miso = mi[b];
                wait_clk(HALF); spi_sck = ~spi_sck;
                wait_clk(HALF);
            end
        end
        wait_clk(2);
        spi_cs = ~cfg_cs_high;
        wait_clk(6);
    endtask

    task automatic send_word(input logic [MAX_WORD-1:0] mo, input logic [MAX_WORD-1:0] mi, input bit cs_act);
        send_bits(mo, mi, cs_act, int'(cfg_word_len));
        exp_cnt = (exp_cnt + 1) % (1 << CNT_W);
    endtask

    task automatic expect_word(input logic [MAX_WORD-1:0] mo, input logic [MAX_WORD-1:0] mi,
                               input logic w, input string tag);
        logic [MAX_WORD-1:0] mask;
        mask = (int'(cfg_word_len) >= MAX_WORD) ? '1 : ((MAX_WORD'(1) << cfg_word_len) - 1'b1);
        chk(mosi_word == (mo & mask), {tag, " mosi"}, 64'(mosi_word), 64'(mo & mask));
        chk(miso_word == (mi & mask), {tag, " miso"}, 64'(miso_word), 64'(mi & mask));
        chk(word_warn == w, {tag, " warn"}, 64'(word_warn), 64'(w));
        chk(int'(word_count) == exp_cnt, {tag, " count"}, 64'(word_count), 64'(exp_cnt));
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        finish_run();
    end

    initial begin
        // Mode 0, MSB first, 8 bits, active-low chip select
        apply_cfg(0, 0, 0, 0, 8);
        chk(word_count == '0 && !word_valid && mosi_word == '0 && miso_word == '0 && !word_warn,
            "R10 reset state", 64'(word_count), 64'd0);
        send_word(32'hA5, 32'h3C, 1);
        expect_word(32'hA5, 32'h3C, 0, "R1 mode0 rising R3 both lines");

        // Mode 1, LSB first
        apply_cfg(0, 1, 0, 1, 8);
        send_word(32'h96, 32'h01, 1);
        expect_word(32'h96, 32'h01, 0, "R4 lsb first mode1");
        send_word(32'h80, 32'h7F, 1);
        expect_word(32'h80, 32'h7F, 0, "R5 back to back words");

        // Mode 2, 5-bit words
        apply_cfg(1, 0, 0, 0, 5);
        send_word(32'h13, 32'h0C, 1);
        expect_word(32'h13, 32'h0C, 0, "R5 length five R1 mode2 falling");

        // Mode 3, maximum length; idle level 1 at reset
        apply_cfg(1, 1, 0, 0, 32);
        send_word(32'hDEADBEEF, 32'h12345678, 1);
        expect_word(32'hDEADBEEF, 32'h12345678, 0, "R5 max length R1 mode3 R10 idle level");

        // 1-bit words, counter wrap
        apply_cfg(0, 0, 0, 0, 1);
        for (int n = 0; n < 16; n++) send_word(32'(n & 1), 32'(~n & 1), 1);
        chk(word_count == '0, "R8 count wraps to zero", 64'(word_count), 64'd0);
        send_word(32'h1, 32'h0, 1);
        expect_word(32'h1, 32'h0, 0, "R8 after wrap");

        // Chip select inactive at the first bit
        apply_cfg(0, 0, 0, 0, 8);
        send_word(32'h5A, 32'hC3, 0);
        expect_word(32'h5A, 32'hC3, 1, "R7 warn set");
        send_word(32'h0F, 32'hF0, 1);
        expect_word(32'h0F, 32'hF0, 0, "R7 warn cleared");

        // Active-high chip select
        apply_cfg(0, 0, 1, 0, 8);
        send_word(32'h33, 32'hCC, 1);
        expect_word(32'h33, 32'hCC, 0, "R6 high active no warn");
        send_word(32'h44, 32'h22, 0);
        expect_word(32'h44, 32'h22, 1, "R6 low is inactive");

        // Data and chip select activity without clock transitions
        for (int n = 0; n < 50; n++) begin
            spi_mosi = n[0]; spi_miso = n[1]; spi_cs = n[2];
            wait_clk(1);
        end
        spi_cs = ~cfg_cs_high;
        wait_clk(6);
        expect_word(32'h44, 32'h22, 1, "R2 no clock no change");

        // Reset in the middle of a word
        apply_cfg(0, 1, 0, 0, 8);
        send_bits(32'hFF, 32'hFF, 1, 3);
        apply_cfg(0, 1, 0, 0, 8);
        send_word(32'h81, 32'h18, 1);
        expect_word(32'h81, 32'h18, 0, "R10 partial word discarded");

        wait_clk(5);
        finish_run();
    end
endmodule